// File: doc/BRIEF.md
# Conditional Trap and System Call Entry Stage

This execute-stage block serves a 64-bit core. It decides whether a trap-word or trap-doubleword instruction (register or immediate form) must trap, and it performs the interrupt entry for a system call. When entry happens, the block produces the new next-instruction address, the save/restore register pair values (SRR0 holds the return address, SRR1 holds the saved machine state) and a new machine state register (MSR) value. Each of these four values has its own write strobe.

A side-band trap type lets the decoder force an unconditional trap to a vector it supplies. This trap does not depend on the operands. Conditional traps and system calls use the same entry path and differ only in the vector and the return address. All register bit numbers in this brief use MSB-0 numbering: architectural bit n of a 64-bit register is physical bit 63-n.

The outputs are registered. A request presented in one cycle appears on the outputs after the next rising clock edge.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four write strobes are low after that edge.
- R2: For a trap opcode, the five condition bits `cond_i[4:0]` enable, from bit 4 down to bit 0: signed less-than, signed greater-than, equal, unsigned less-than and unsigned greater-than, each testing operand A against operand B. The trap is taken when at least one enabled relation holds. The result appears one clock after the request.
- R3: The word opcodes (1 and 2) compare only the low 32 bits of each operand, sign-extended for the signed tests and zero-extended for the others. The doubleword opcodes (3 and 4) compare all 64 bits.
- R4: The immediate opcodes (2 and 4) use `imm_i` sign-extended from 16 bits in place of `rb_i`.
- R5: A taken conditional trap writes 0x700 to the next address, the instruction address `cia_i` to SRR0, and `msr_i` with architectural bit 46 (physical bit 17) set to SRR1.
- R6: On a trap opcode with nonzero `force_type_i`, the trap is taken regardless of condition bits and operands, and the next address is `force_vec_i`. If that vector equals 0x700, SRR1 is `msr_i` with `force_type_i` ORed into architectural bits 43..46 (physical bits 20..17, with `force_type_i[3]` at architectural bit 43). For any other vector, SRR1 is `msr_i` unchanged.
- R7: The system call opcode (5) always enters at 0xC00. SRR0 receives `cia_i + 4`, SRR1 receives `msr_i` unchanged, and `force_type_i` has no effect.
- R8: On any entry, the new MSR is `msr_i` with architectural bits 48, 49, 58 and 59 (physical 15, 14, 5, 4) cleared and architectural bit 0 (physical 63) set. All four strobes rise together.
- R9: Opcode 0, opcodes 6 and 7, and untaken traps leave all four write strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Opcode: 0 none, 1 word reg, 2 word imm, 3 dword reg, 4 dword imm, 5 system call |
| cond_i | input | 5 | Trap condition enable mask |
| ra_i | input | 64 | Operand A |
| rb_i | input | 64 | Operand B (register forms) |
| imm_i | input | 16 | Immediate operand B (immediate forms) |
| cia_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state |
| force_type_i | input | 4 | Nonzero forces an unconditional trap; reason flags |
| force_vec_i | input | 64 | Vector used by a forced trap |
| nia_o | output | 64 | Next instruction address |
| nia_we_o | output | 1 | Next address write strobe |
| srr0_o | output | 64 | Saved return address |
| srr0_we_o | output | 1 | SRR0 write strobe |
| srr1_o | output | 64 | Saved machine state with reason flags |
| srr1_we_o | output | 1 | SRR1 write strobe |
| msr_o | output | 64 | New machine state |
| msr_we_o | output | 1 | MSR write strobe |

## Verification
The hardest cases to reach from the ports are the word-form traps whose upper operand halves disagree with the lower halves. Examples are equal low words with different high words, or a low word that is negative while the full doubleword is positive. Random operands almost never produce these. The stimulus therefore builds operand B from operand A by copying or flipping chosen halves. It also seeds directed cases with sign-boundary words and immediates of -1. A forced trap whose supplied vector happens to be exactly 0x700 is also injected on purpose, so that the flag-merge path is exercised next to the plain-copy path.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  localparam logic [2:0] OPC_NONE = 3'd0;
  localparam logic [2:0] OPC_TW   = 3'd1;
  localparam logic [2:0] OPC_TWI  = 3'd2;
  localparam logic [2:0] OPC_TD   = 3'd3;
  localparam logic [2:0] OPC_TDI  = 3'd4;
  localparam logic [2:0] OPC_SC   = 3'd5;

  // architectural (MSB-0) bit numbers
  localparam int unsigned AB_SF      = 0;
  localparam int unsigned AB_EE      = 48;
  localparam int unsigned AB_PR      = 49;
  localparam int unsigned AB_IR      = 58;
  localparam int unsigned AB_DR      = 59;
  localparam int unsigned AB_FLAG_LO = 46;  // least significant reason flag

  typedef struct packed {
    logic lt_s;
    logic gt_s;
    logic eq;
    logic lt_u;
    logic gt_u;
  } cmp_res_t;

  function automatic int unsigned phys_bit(input int unsigned arch, input int unsigned width);
    return width - 1 - arch;
  endfunction
endpackage

// File: rtl/trap_cmp.sv
`timescale 1ns/1ps
module trap_cmp
  import trap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            word_mode,
  output cmp_res_t        res
);
  localparam int HI = XLEN - WORD;

  logic [XLEN-1:0] a_sx, b_sx, a_zx, b_zx;

  always_comb begin
    if (word_mode) begin
      a_sx = {{HI{a[WORD-1]}}, a[WORD-1:0]};
      b_sx = {{HI{b[WORD-1]}}, b[WORD-1:0]};
      a_zx = {{HI{1'b0}}, a[WORD-1:0]};
      b_zx = {{HI{1'b0}}, b[WORD-1:0]};
    end else begin
      a_sx = a;
      b_sx = b;
      a_zx = a;
      b_zx = b;
    end
    res.lt_s = $signed(a_sx) < $signed(b_sx);
    res.gt_s = $signed(a_sx) > $signed(b_sx);
    res.eq   = a_zx == b_zx;
    res.lt_u = a_zx < b_zx;
    res.gt_u = a_zx > b_zx;
  end
endmodule

// File: rtl/trap_decide.sv
`timescale 1ns/1ps
module trap_decide
  import trap_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter int              FTYPE_W  = 4,
  parameter logic [XLEN-1:0] PROG_VEC = 64'h700,
  parameter logic [XLEN-1:0] SC_VEC   = 64'hC00
) (
  input  logic [2:0]         op,
  input  logic [4:0]         cond,
  input  cmp_res_t           res,
  input  logic [FTYPE_W-1:0] force_type,
  input  logic [XLEN-1:0]    force_vec,
  output logic               take,
  output logic               is_sc,
  output logic [XLEN-1:0]    vec,
  output logic [FTYPE_W-1:0] flags
);
  localparam logic [FTYPE_W-1:0] COND_FLAG = FTYPE_W'(1);

  logic is_trap, forced, hit;

  always_comb begin
    is_trap = (op == OPC_TW) || (op == OPC_TWI) || (op == OPC_TD) || (op == OPC_TDI);
    is_sc   = (op == OPC_SC);
    forced  = is_trap && (force_type != '0);
    hit     = |(cond & res);
    take    = is_sc || (is_trap && (forced || hit));

    if (is_sc)       vec = SC_VEC;
    else if (forced) vec = force_vec;
    else             vec = PROG_VEC;

    flags = '0;
    if (!is_sc && vec == PROG_VEC)
      flags = forced ? force_type : COND_FLAG;
  end
endmodule

// File: rtl/trap_state_build.sv
`timescale 1ns/1ps
module trap_state_build
  import trap_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int FTYPE_W    = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]    cia,
  input  logic [XLEN-1:0]    msr,
  input  logic               is_sc,
  input  logic [FTYPE_W-1:0] flags,
  output logic [XLEN-1:0]    srr0,
  output logic [XLEN-1:0]    srr1,
  output logic [XLEN-1:0]    msr_new
);
  localparam int FLAG_LSB = phys_bit(AB_FLAG_LO, XLEN);
  localparam int P_SF = phys_bit(AB_SF, XLEN);
  localparam int P_EE = phys_bit(AB_EE, XLEN);
  localparam int P_PR = phys_bit(AB_PR, XLEN);
  localparam int P_IR = phys_bit(AB_IR, XLEN);
  localparam int P_DR = phys_bit(AB_DR, XLEN);

  logic [XLEN-1:0] flag_mask;

  genvar g;
  generate
    for (g = 0; g < XLEN; g++) begin : g_flag
      if (g >= FLAG_LSB && g < FLAG_LSB + FTYPE_W) begin : g_in
        assign flag_mask[g] = flags[g - FLAG_LSB];
      end else begin : g_out
        assign flag_mask[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    srr0 = is_sc ? cia + XLEN'(INSN_BYTES) : cia;
    srr1 = msr | flag_mask;
    msr_new = msr;
    msr_new[P_EE] = 1'b0;
    msr_new[P_PR] = 1'b0;
    msr_new[P_IR] = 1'b0;
    msr_new[P_DR] = 1'b0;
    msr_new[P_SF] = 1'b1;
  end
endmodule

// File: rtl/trap_entry_unit.sv
`timescale 1ns/1ps
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter int              WORD       = 32,
  parameter int              IMM_W      = 16,
  parameter int              FTYPE_W    = 4,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] PROG_VEC   = 64'h700,
  parameter logic [XLEN-1:0] SC_VEC     = 64'hC00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         op_i,
  input  logic [4:0]         cond_i,
  input  logic [XLEN-1:0]    ra_i,
  input  logic [XLEN-1:0]    rb_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [XLEN-1:0]    cia_i,
  input  logic [XLEN-1:0]    msr_i,
  input  logic [FTYPE_W-1:0] force_type_i,
  input  logic [XLEN-1:0]    force_vec_i,
  output logic [XLEN-1:0]    nia_o,
  output logic               nia_we_o,
  output logic [XLEN-1:0]    srr0_o,
  output logic               srr0_we_o,
  output logic [XLEN-1:0]    srr1_o,
  output logic               srr1_we_o,
  output logic [XLEN-1:0]    msr_o,
  output logic               msr_we_o
);
  localparam int IMM_EXT = XLEN - IMM_W;

  logic              word_mode, use_imm;
  logic [XLEN-1:0]   opb;
  cmp_res_t          res;
  logic              take, is_sc;
  logic [XLEN-1:0]   vec, srr0_n, srr1_n, msr_n;
  logic [FTYPE_W-1:0] flags;

  always_comb begin
    word_mode = (op_i == OPC_TW) || (op_i == OPC_TWI);
    use_imm   = (op_i == OPC_TWI) || (op_i == OPC_TDI);
    opb       = use_imm ? {{IMM_EXT{imm_i[IMM_W-1]}}, imm_i} : rb_i;
  end

  trap_cmp #(.XLEN(XLEN), .WORD(WORD)) u_cmp (
    .a(ra_i), .b(opb), .word_mode(word_mode), .res(res)
  );

  trap_decide #(.XLEN(XLEN), .FTYPE_W(FTYPE_W), .PROG_VEC(PROG_VEC), .SC_VEC(SC_VEC)) u_decide (
    .op(op_i), .cond(cond_i), .res(res), .force_type(force_type_i),
    .force_vec(force_vec_i), .take(take), .is_sc(is_sc), .vec(vec), .flags(flags)
  );

  trap_state_build #(.XLEN(XLEN), .FTYPE_W(FTYPE_W), .INSN_BYTES(INSN_BYTES)) u_build (
    .cia(cia_i), .msr(msr_i), .is_sc(is_sc), .flags(flags),
    .srr0(srr0_n), .srr1(srr1_n), .msr_new(msr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nia_o     <= '0;
      srr0_o    <= '0;
      srr1_o    <= '0;
      msr_o     <= '0;
      nia_we_o  <= 1'b0;
      srr0_we_o <= 1'b0;
      srr1_we_o <= 1'b0;
      msr_we_o  <= 1'b0;
    end else begin
      nia_o     <= vec;
      srr0_o    <= srr0_n;
      srr1_o    <= srr1_n;
      msr_o     <= msr_n;
      nia_we_o  <= take;
      srr0_we_o <= take;
      srr1_we_o <= take;
      msr_we_o  <= take;
    end
  end
endmodule

// File: rtl/trap_entry_unit_chk.sv
`timescale 1ns/1ps
module trap_entry_unit_chk
  import trap_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter int              FTYPE_W    = 4,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] SC_VEC     = 64'hC00
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         op_i,
  input logic [FTYPE_W-1:0] force_type_i,
  input logic [XLEN-1:0]    force_vec_i,
  input logic [XLEN-1:0]    cia_i,
  input logic [XLEN-1:0]    msr_i,
  input logic [XLEN-1:0]    nia_o,
  input logic               nia_we_o,
  input logic [XLEN-1:0]    srr0_o,
  input logic               srr0_we_o,
  input logic [XLEN-1:0]    srr1_o,
  input logic               srr1_we_o,
  input logic [XLEN-1:0]    msr_o,
  input logic               msr_we_o
);
  localparam int P_SF = phys_bit(AB_SF, XLEN);
  localparam int P_EE = phys_bit(AB_EE, XLEN);
  localparam int P_PR = phys_bit(AB_PR, XLEN);
  localparam int P_IR = phys_bit(AB_IR, XLEN);
  localparam int P_DR = phys_bit(AB_DR, XLEN);

  logic is_trap_op;
  assign is_trap_op = (op_i == OPC_TW) || (op_i == OPC_TWI) || (op_i == OPC_TD) || (op_i == OPC_TDI);

  // R8
  strobes_together_chk: assert property (@(posedge clk) disable iff (rst)
    nia_we_o |-> (srr0_we_o && srr1_we_o && msr_we_o));

  // R8
  new_msr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    msr_we_o |-> (msr_o[P_SF] && !msr_o[P_EE] && !msr_o[P_PR] && !msr_o[P_IR] && !msr_o[P_DR]));

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_trap_op && op_i != OPC_SC) |=> !(nia_we_o || srr0_we_o || srr1_we_o || msr_we_o));

  // R7
  syscall_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OPC_SC) |=> (nia_we_o && nia_o == SC_VEC
                          && srr0_o == $past(cia_i) + XLEN'(INSN_BYTES)
                          && srr1_o == $past(msr_i)));

  // R6
  forced_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (is_trap_op && force_type_i != '0) |=> (nia_we_o && nia_o == $past(force_vec_i)));

  // R5
  trap_return_addr_chk: assert property (@(posedge clk) disable iff (rst)
    is_trap_op |=> (!srr0_we_o || srr0_o == $past(cia_i)));
endmodule

bind trap_entry_unit trap_entry_unit_chk #(
  .XLEN(XLEN), .FTYPE_W(FTYPE_W), .INSN_BYTES(INSN_BYTES), .SC_VEC(SC_VEC)
) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .force_type_i(force_type_i),
  .force_vec_i(force_vec_i), .cia_i(cia_i), .msr_i(msr_i),
  .nia_o(nia_o), .nia_we_o(nia_we_o), .srr0_o(srr0_o), .srr0_we_o(srr0_we_o),
  .srr1_o(srr1_o), .srr1_we_o(srr1_we_o), .msr_o(msr_o), .msr_we_o(msr_we_o)
);

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [4:0]  cond_i = '0;
  logic [63:0] ra_i = '0, rb_i = '0, cia_i = '0, msr_i = '0, force_vec_i = '0;
  logic [15:0] imm_i = '0;
  logic [3:0]  force_type_i = '0;
  logic [63:0] nia_o, srr0_o, srr1_o, msr_o;
  logic        nia_we_o, srr0_we_o, srr1_we_o, msr_we_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_entry_unit uut (
    .clk(clk), .rst(rst), .op_i(op_i), .cond_i(cond_i), .ra_i(ra_i), .rb_i(rb_i),
    .imm_i(imm_i), .cia_i(cia_i), .msr_i(msr_i), .force_type_i(force_type_i),
    .force_vec_i(force_vec_i), .nia_o(nia_o), .nia_we_o(nia_we_o), .srr0_o(srr0_o),
    .srr0_we_o(srr0_we_o), .srr1_o(srr1_o), .srr1_we_o(srr1_we_o), .msr_o(msr_o),
    .msr_we_o(msr_we_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected trap decision from the requirement text
  function automatic bit exp_hit(input logic [2:0] op, input logic [4:0] c,
                                 input logic [63:0] a, input logic [63:0] b0, input logic [15:0] im);
    logic [63:0] b, sa, sb, ua, ub;
    b = (op == 3'd2 || op == 3'd4) ? {{48{im[15]}}, im} : b0;
    if (op == 3'd1 || op == 3'd2) begin
      sa = {{32{a[31]}}, a[31:0]}; sb = {{32{b[31]}}, b[31:0]};
      ua = {32'd0, a[31:0]};       ub = {32'd0, b[31:0]};
    end else begin
      sa = a; sb = b; ua = a; ub = b;
    end
    return (c[4] && $signed(sa) < $signed(sb)) || (c[3] && $signed(sa) > $signed(sb)) ||
           (c[2] && ua == ub) || (c[1] && ua < ub) || (c[0] && ua > ub);
  endfunction

  task automatic apply_and_check(input string req, input logic [2:0] op, input logic [4:0] c,
                                 input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
                                 input logic [63:0] cia, input logic [63:0] msr,
                                 input logic [3:0] ft, input logic [63:0] fv);
    bit is_trap, take;
    logic [63:0] e_nia, e_srr0, e_srr1, e_msr;
    op_i = op; cond_i = c; ra_i = a; rb_i = b; imm_i = im;
    cia_i = cia; msr_i = msr; force_type_i = ft; force_vec_i = fv;
    is_trap = (op >= 3'd1 && op <= 3'd4);
    e_msr = msr;
    e_msr[15] = 1'b0; e_msr[14] = 1'b0; e_msr[5] = 1'b0; e_msr[4] = 1'b0; e_msr[63] = 1'b1;
    e_srr1 = msr;
    if (op == 3'd5) begin
      take = 1; e_nia = 64'hC00; e_srr0 = cia + 64'd4;
    end else if (is_trap && ft != 0) begin
      take = 1; e_nia = fv; e_srr0 = cia;
      if (fv == 64'h700) e_srr1 = msr | ({60'd0, ft} << 17);
    end else begin
      take = is_trap && exp_hit(op, c, a, b, im);
      e_nia = 64'h700; e_srr0 = cia; e_srr1 = msr | (64'd1 << 17);
    end
    @(negedge clk);
    chk(req, "nia_we", {63'd0, nia_we_o}, {63'd0, take});
    chk(req, "strobes", {61'd0, srr0_we_o, srr1_we_o, msr_we_o}, {61'd0, take, take, take});
    if (take) begin
      chk(req, "nia", nia_o, e_nia);
      chk(req, "srr0", srr0_o, e_srr0);
      chk(req, "srr1", srr1_o, e_srr1);
      chk(req, "msr R8", msr_o, e_msr);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "strobes", {60'd0, nia_we_o, srr0_we_o, srr1_we_o, msr_we_o}, 64'd0);
    op_i = 3'd5;
    @(negedge clk);
    chk("R1", "strobes under reset", {60'd0, nia_we_o, srr0_we_o, srr1_we_o, msr_we_o}, 64'd0);
    rst = 1'b0;

    // R3: low words equal, high halves differ -> word eq traps, dword eq does not
    apply_and_check("R3", 3'd1, 5'b00100, 64'h1111_1111_8000_0000, 64'h2222_2222_8000_0000, 16'd0, 64'h1000, 64'hFFFF_0000_FFFF_FFFF, 4'd0, 64'd0);
    apply_and_check("R3", 3'd3, 5'b00100, 64'h1111_1111_8000_0000, 64'h2222_2222_8000_0000, 16'd0, 64'h1004, 64'h0, 4'd0, 64'd0);
    // R2: signed vs unsigned disagreement on word sign boundary
    apply_and_check("R2", 3'd1, 5'b10000, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 16'd0, 64'h2000, 64'h1234, 4'd0, 64'd0);
    apply_and_check("R2", 3'd1, 5'b00010, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 16'd0, 64'h2004, 64'h1234, 4'd0, 64'd0);
    apply_and_check("R2", 3'd3, 5'b00000, 64'd5, 64'd5, 16'd0, 64'h2008, 64'h1, 4'd0, 64'd0);
    // R4: immediate -1 against all-ones word and doubleword
    apply_and_check("R4", 3'd2, 5'b00100, 64'h0000_0000_FFFF_FFFF, 64'd0, 16'hFFFF, 64'h3000, 64'hC000, 4'd0, 64'd0);
    apply_and_check("R4", 3'd4, 5'b00100, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 64'h3004, 64'hC000, 4'd0, 64'd0);
    // R6: forced trap ignores mask, to 0x700 with flags, and to another vector without
    apply_and_check("R6", 3'd3, 5'b00000, 64'd1, 64'd2, 16'd0, 64'h4000, 64'h8000_0000_0000_C030, 4'b1010, 64'h700);
    apply_and_check("R6", 3'd1, 5'b00000, 64'd1, 64'd2, 16'd0, 64'h4004, 64'h8000_0000_0000_C030, 4'b0110, 64'h900);
    // R7: system call, force type ignored
    apply_and_check("R7", 3'd5, 5'b11111, 64'd0, 64'd0, 16'd0, 64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1111, 64'h700);
    // R9: idle and reserved opcodes
    apply_and_check("R9", 3'd0, 5'b11111, 64'd1, 64'd1, 16'd1, 64'h5000, 64'h0, 4'd3, 64'h700);
    apply_and_check("R9", 3'd6, 5'b11111, 64'd1, 64'd1, 16'd1, 64'h5004, 64'h0, 4'd3, 64'h700);
    apply_and_check("R9", 3'd7, 5'b00100, 64'd1, 64'd1, 16'd1, 64'h5008, 64'h0, 4'd0, 64'h0);
    // R5: plain conditional program trap
    apply_and_check("R5", 3'd3, 5'b01000, 64'd9, 64'd3, 16'd0, 64'h6000, 64'h0000_0000_0001_C030, 4'd0, 64'd0);

    // R2 R3 R4 R6 R7 R8: constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [63:0] a, b, fv;
      logic [3:0] ft;
      int sel;
      op = 3'($urandom_range(0, 7));
      a = {$urandom, $urandom};
      sel = $urandom_range(0, 3);
      case (sel)
        0: b = a;
        1: b = {~a[63:32], a[31:0]};
        2: b = {a[63:32], a[31:0] + 32'($urandom_range(0, 2)) - 32'd1};
        default: b = {$urandom, $urandom};
      endcase
      ft = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0;
      fv = ($urandom_range(0, 1) == 0) ? 64'h700 : {$urandom, $urandom};
      apply_and_check("R2", op, 5'($urandom), a, b, 16'($urandom), {$urandom, $urandom},
                      {$urandom, $urandom}, ft, fv);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule